// File: doc/BRIEF.md
# USART Mode and Command Controller

This block holds the configuration and status state of an asynchronous USART. A single byte-wide write port feeds it. After any reset, the first byte written is taken as the mode byte. Every byte after that is a command byte.

The mode byte sets four things for the transmitter and the receiver:
- the sampling-clock multiplier;
- the character length;
- parity enable and parity sense;
- the stop-bit length.

A command byte sets the transmitter and receiver enables, two modem control outputs and the break level. Two command bits act once and are not stored:
- the error-flag clear;
- an internal reset, which re-arms the write sequence so that the next byte is a mode byte again.

The block also builds the status byte. It combines the ready and empty flags from the transmitter and receiver with a modem status line and three sticky receive-error flags. The serial shifters are separate blocks. They take their settings from this controller and report their flags and error events back to it.

Top module: `usart_cfg_ctrl`

## Requirements
- R1: After reset (rst_n low), the block is in this state:
  - wait_mode_o is 1.
  - rate_mult_o is 0, char_bits_o is 5 and stop_halves_o is 2.
  - All enables, modem control outputs, break_o and int_rst_o are 0.
  - Status bits 3, 4 and 5 are 0.
- R2: The write sequence works as follows:
  - While wait_mode_o is 1, a write loads the mode register and drops wait_mode_o to 0.
  - While wait_mode_o is 0, every write is a command, and wait_mode_o stays 0 unless that command has bit 6 set.
  - Bit 6 of a mode byte does not reset anything.
- R3: Mode bits 3:2 give char_bits_o = 5 + field (00→5, 01→6, 10→7, 11→8). Mode bit 4 drives parity_en_o and mode bit 5 drives parity_even_o.
- R4: Mode bits 1:0 give rate_mult_o: 00→0 (unused), 01→1, 10→16, 11→64.
- R5: Mode bits 7:6 give stop_halves_o in half-bit units: 00→2, 01→2, 10→3, 11→4.
- R6: A command without bit 6 loads the held outputs:
  - bit 0 → tx_en_o and bit 2 → rx_en_o;
  - bit 1 → modem_ctl_a_o and bit 5 → modem_ctl_b_o;
  - bit 3 → break_o.
  
  These hold their values until the next command or reset.
- R7: A command with bit 6 set raises int_rst_o for the cycle of that write. On the next cycle the block is in this state:
  - wait_mode_o is 1.
  - The mode and command state are back to their R1 values.
  - The error flags are clear, unless an error event occurs in that same cycle.
- R8: Error events set sticky status bits:
  - A pulse on rx_par_err_i sets status bit 3.
  - A pulse on rx_ovr_err_i sets status bit 4.
  - A pulse on rx_frm_err_i sets status bit 5.
  
  Each bit stays set through later cycles without events. Only rst_n, an internal reset or an error clear removes it.
- R9: A command with bit 4 set clears all three error flags on the next cycle, and bit 4 is not stored. If an error event arrives in the same cycle as the clear, the event's flag ends up set.
- R10: The status byte is laid out as follows:
  - bit 0 = tx_ready_i, bit 1 = rx_ready_i, bit 2 = tx_empty_i;
  - bits 3 to 5 are the error flags from R8;
  - bit 6 = 0;
  - bit 7 = modem_sts_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous card reset, active low |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Byte written (mode or command) |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| tx_empty_i | input | 1 | Transmitter has nothing left to send |
| rx_ready_i | input | 1 | Receiver holds a character |
| rx_par_err_i | input | 1 | Parity error event pulse |
| rx_ovr_err_i | input | 1 | Overrun error event pulse |
| rx_frm_err_i | input | 1 | Framing error event pulse |
| modem_sts_i | input | 1 | Modem status line reported in status bit 7 |
| status_o | output | 8 | Assembled status byte |
| wait_mode_o | output | 1 | Next write goes to the mode register |
| rate_mult_o | output | 7 | Sampling clock multiplier (0 = unused code) |
| char_bits_o | output | 4 | Data bits per character |
| parity_en_o | output | 1 | Parity generation and checking enabled |
| parity_even_o | output | 1 | Even parity when set, odd when clear |
| stop_halves_o | output | 3 | Stop time in half-bit units |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| modem_ctl_a_o | output | 1 | Modem control output A |
| modem_ctl_b_o | output | 1 | Modem control output B |
| break_o | output | 1 | Hold transmit line at the spacing level |
| int_rst_o | output | 1 | Internal reset pulse for the shifters |

## Verification
The bench builds the block with its default parameters: an 8-bit write port and three error flags. This keeps the byte space small enough to sweep completely. Every one of the 256 values is written once as a mode byte and then once as a command byte, so every mode decode, every combination of command bits and the reset-bit path are each observed in both sequencer states. Separate directed sequences cover the error flags: sticky retention, the one-shot clear, an event colliding with a clear, and the clearing effect of an internal reset and of a card reset.

// File: rtl/usart_cfg_pkg.sv
package usart_cfg_pkg;

  localparam int BYTE_W  = 8;
  localparam int RATE_W  = 7;
  localparam int LEN_W   = 4;
  localparam int STOP_W  = 3;
  localparam int NUM_ERR = 3;
  localparam int HELD_W  = 5;

  // Command bit positions
  localparam int CB_TXEN  = 0;
  localparam int CB_CTLA  = 1;
  localparam int CB_RXEN  = 2;
  localparam int CB_BRK   = 3;
  localparam int CB_ECLR  = 4;
  localparam int CB_CTLB  = 5;
  localparam int CB_IRST  = 6;

  // Error flag order inside the flag vector (status bits 3..5)
  localparam int EF_PAR = 0;
  localparam int EF_OVR = 1;
  localparam int EF_FRM = 2;

  typedef enum logic {SEQ_MODE = 1'b0, SEQ_CMD = 1'b1} seq_t;

  typedef struct packed {
    logic [1:0] stop_sel;
    logic       par_even;
    logic       par_en;
    logic [1:0] len_sel;
    logic [1:0] rate_sel;
  } mode_t;

  function automatic logic [LEN_W-1:0] f_char_bits(input logic [1:0] sel);
    return LEN_W'(5) + LEN_W'(sel);
  endfunction

  function automatic logic [RATE_W-1:0] f_rate_mult(input logic [1:0] sel);
    logic [RATE_W-1:0] r;
    case (sel)
      2'b01:   r = RATE_W'(1);
      2'b10:   r = RATE_W'(16);
      2'b11:   r = RATE_W'(64);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [STOP_W-1:0] f_stop_halves(input logic [1:0] sel);
    logic [STOP_W-1:0] h;
    case (sel)
      2'b10:   h = STOP_W'(3);
      2'b11:   h = STOP_W'(4);
      default: h = STOP_W'(2);
    endcase
    return h;
  endfunction

endpackage

// File: rtl/usart_wr_seq.sv
module usart_wr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic bit_irst,
  input  logic bit_eclr,
  output logic expect_mode,
  output logic mode_load,
  output logic cmd_load,
  output logic int_rst,
  output logic err_clr
);
  import usart_cfg_pkg::*;

  seq_t state_q, state_d;
  logic cmd_wr;

  assign expect_mode = (state_q == SEQ_MODE);
  assign mode_load   = wr_en && expect_mode;
  assign cmd_wr      = wr_en && !expect_mode;
  assign int_rst     = cmd_wr && bit_irst;
  assign cmd_load    = cmd_wr && !bit_irst;
  assign err_clr     = cmd_wr && bit_eclr && !bit_irst;

  always_comb begin
    state_d = state_q;
    if (mode_load)    state_d = SEQ_CMD;
    else if (int_rst) state_d = SEQ_MODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_MODE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/usart_mode_reg.sv
module usart_mode_reg
  import usart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  output logic [RATE_W-1:0] rate_mult,
  output logic [LEN_W-1:0]  char_bits,
  output logic              par_en,
  output logic              par_even,
  output logic [STOP_W-1:0] stop_halves
);
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (clr)   mode_q <= '0;
    else if (load)  mode_q <= mode_t'(data);
  end

  assign rate_mult   = f_rate_mult(mode_q.rate_sel);
  assign char_bits   = f_char_bits(mode_q.len_sel);
  assign par_en      = mode_q.par_en;
  assign par_even    = mode_q.par_even;
  assign stop_halves = f_stop_halves(mode_q.stop_sel);
endmodule

// File: rtl/usart_cmd_reg.sv
module usart_cmd_reg #(
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [HW-1:0] held_d,
  output logic [HW-1:0] held_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (clr)  held_q <= '0;
    else if (load) held_q <= held_d;
  end
endmodule

// File: rtl/usart_err_flags.sv
module usart_err_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[g] <= 1'b0;
      else if (evt[g]) flag[g] <= 1'b1;
      else if (clr)    flag[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_cfg_ctrl.sv
module usart_cfg_ctrl
  import usart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tx_ready_i,
  input  logic              tx_empty_i,
  input  logic              rx_ready_i,
  input  logic              rx_par_err_i,
  input  logic              rx_ovr_err_i,
  input  logic              rx_frm_err_i,
  input  logic              modem_sts_i,
  output logic [BYTE_W-1:0] status_o,
  output logic              wait_mode_o,
  output logic [RATE_W-1:0] rate_mult_o,
  output logic [LEN_W-1:0]  char_bits_o,
  output logic              parity_en_o,
  output logic              parity_even_o,
  output logic [STOP_W-1:0] stop_halves_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              modem_ctl_a_o,
  output logic              modem_ctl_b_o,
  output logic              break_o,
  output logic              int_rst_o
);
  // Named internal events (observed by the bound checker)
  logic               expect_mode;
  logic               mode_load;
  logic               cmd_load;
  logic               int_rst_pulse;
  logic               err_clr_pulse;
  logic [NUM_ERR-1:0] err_evt;
  logic [NUM_ERR-1:0] err_flag;
  logic [HELD_W-1:0]  held_d;
  logic [HELD_W-1:0]  held_q;

  usart_wr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .bit_irst    (wr_data[CB_IRST]),
    .bit_eclr    (wr_data[CB_ECLR]),
    .expect_mode (expect_mode),
    .mode_load   (mode_load),
    .cmd_load    (cmd_load),
    .int_rst     (int_rst_pulse),
    .err_clr     (err_clr_pulse)
  );

  usart_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (int_rst_pulse),
    .load        (mode_load),
    .data        (wr_data),
    .rate_mult   (rate_mult_o),
    .char_bits   (char_bits_o),
    .par_en      (parity_en_o),
    .par_even    (parity_even_o),
    .stop_halves (stop_halves_o)
  );

  assign held_d = {wr_data[CB_CTLB], wr_data[CB_BRK], wr_data[CB_RXEN],
                   wr_data[CB_CTLA], wr_data[CB_TXEN]};

  usart_cmd_reg #(.HW(HELD_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (int_rst_pulse),
    .load   (cmd_load),
    .held_d (held_d),
    .held_q (held_q)
  );

  assign tx_en_o       = held_q[0];
  assign modem_ctl_a_o = held_q[1];
  assign rx_en_o       = held_q[2];
  assign break_o       = held_q[3];
  assign modem_ctl_b_o = held_q[4];

  assign err_evt[EF_PAR] = rx_par_err_i;
  assign err_evt[EF_OVR] = rx_ovr_err_i;
  assign err_evt[EF_FRM] = rx_frm_err_i;

  usart_err_flags #(.N(NUM_ERR)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (err_clr_pulse || int_rst_pulse),
    .evt   (err_evt),
    .flag  (err_flag)
  );

  assign status_o = {modem_sts_i, 1'b0, err_flag[EF_FRM], err_flag[EF_OVR],
                     err_flag[EF_PAR], tx_empty_i, rx_ready_i, tx_ready_i};

  assign wait_mode_o = expect_mode;
  assign int_rst_o   = int_rst_pulse;
endmodule

// File: rtl/usart_cfg_ctrl_chk.sv
module usart_cfg_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       expect_mode,
  input logic       int_rst_pulse,
  input logic       err_clr_pulse,
  input logic [2:0] err_evt,
  input logic [2:0] err_flag,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       break_o,
  input logic [3:0] char_bits_o,
  input logic [6:0] rate_mult_o
);
  AST_MODE_THEN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && expect_mode) |=> !expect_mode); // R2

  AST_CMD_KEEPS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!expect_mode && !int_rst_pulse) |=> !expect_mode); // R2

  AST_IRST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_pulse |=> (expect_mode && !tx_en_o && !rx_en_o && !break_o)); // R7

  AST_IRST_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst_pulse && err_evt == 3'b000) |=> (err_flag == 3'b000)); // R7

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[0] |=> err_flag[0]); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag[2] && !err_clr_pulse && !int_rst_pulse) |=> err_flag[2]); // R8

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_pulse && err_evt == 3'b000) |=> (err_flag == 3'b000)); // R9

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(break_o) && $stable(tx_en_o) && $stable(rx_en_o))); // R6

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(char_bits_o) && $stable(rate_mult_o))); // R3
endmodule

bind usart_cfg_ctrl usart_cfg_ctrl_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .expect_mode   (expect_mode),
  .int_rst_pulse (int_rst_pulse),
  .err_clr_pulse (err_clr_pulse),
  .err_evt       (err_evt),
  .err_flag      (err_flag),
  .tx_en_o       (tx_en_o),
  .rx_en_o       (rx_en_o),
  .break_o       (break_o),
  .char_bits_o   (char_bits_o),
  .rate_mult_o   (rate_mult_o)
);

// File: tb/test_usart_cfg_ctrl.sv
module test_usart_cfg_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_ready_i = 1'b0, tx_empty_i = 1'b0, rx_ready_i = 1'b0;
  logic       rx_par_err_i = 1'b0, rx_ovr_err_i = 1'b0, rx_frm_err_i = 1'b0;
  logic       modem_sts_i = 1'b0;
  logic [7:0] status_o;
  logic       wait_mode_o;
  logic [6:0] rate_mult_o;
  logic [3:0] char_bits_o;
  logic       parity_en_o, parity_even_o;
  logic [2:0] stop_halves_o;
  logic       tx_en_o, rx_en_o, modem_ctl_a_o, modem_ctl_b_o, break_o, int_rst_o;

  int checks = 0;
  int errors = 0;
  logic pulse_seen;

  always #5 clk = ~clk;

  usart_cfg_ctrl i_usart_cfg_ctrl (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle write; records int_rst_o during the write cycle
  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    #1 pulse_seen = int_rst_o;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic chk_mode(input string req, input logic [7:0] m);
    int bits, rate, halves;
    bits = 5 + int'(m[3]) * 2 + int'(m[2]);
    rate = (m[1:0] == 2'd0) ? 0 : (1 << (2 * (int'(m[1:0]) - 1) * 2 / 2 * 1)) ;
    if (m[1:0] == 2'd2) rate = 16;
    if (m[1:0] == 2'd3) rate = 64;
    halves = (m[7:6] == 2'd3) ? 4 : (m[7:6] == 2'd2) ? 3 : 2;
    chk({req, " R3 char bits"}, char_bits_o, bits);
    chk({req, " R3 parity en"}, parity_en_o, m[4]);
    chk({req, " R3 parity even"}, parity_even_o, m[5]);
    chk({req, " R4 rate"}, rate_mult_o, rate);
    chk({req, " R5 stop"}, stop_halves_o, halves);
  endtask

  task automatic chk_held(input string req, input logic [7:0] c);
    chk({req, " R6 tx_en"}, tx_en_o, c[0]);
    chk({req, " R6 ctl_a"}, modem_ctl_a_o, c[1]);
    chk({req, " R6 rx_en"}, rx_en_o, c[2]);
    chk({req, " R6 break"}, break_o, c[3]);
    chk({req, " R6 ctl_b"}, modem_ctl_b_o, c[5]);
  endtask

  task automatic err_evt(input logic p, input logic o, input logic f);
    @(negedge clk);
    rx_par_err_i = p; rx_ovr_err_i = o; rx_frm_err_i = f;
    @(negedge clk);
    rx_par_err_i = 0; rx_ovr_err_i = 0; rx_frm_err_i = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wait_mode", wait_mode_o, 1);
    chk_mode("R1", 8'h00);
    chk_held("R1", 8'h00);
    chk("R1 int_rst", int_rst_o, 0);
    chk("R1 err bits", status_o[5:3], 0);

    // Exhaustive sweep: each value as mode byte, then as command byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      wr(b);
      chk("R2 mode write no reset", pulse_seen, 0);
      chk("R2 after mode", wait_mode_o, 0);
      chk_mode("sweep", b);
      wr(b);
      if (b[6]) begin
        chk("R7 pulse", pulse_seen, 1);
        chk("R7 rearm", wait_mode_o, 1);
        chk_mode("R7 cleared", 8'h00);
        chk_held("R7 cleared", 8'h00);
      end else begin
        chk("R2 cmd no pulse", pulse_seen, 0);
        chk("R2 still cmd", wait_mode_o, 0);
        chk_held("sweep", b);
        chk_mode("R2 mode kept", b);
        wr(8'h00);
        chk("R2 second cmd", wait_mode_o, 0);
        chk_held("R6 second", 8'h00);
        wr(8'h40);
        chk("R7 pulse", pulse_seen, 1);
        chk("R7 rearm", wait_mode_o, 1);
      end
    end

    // Error flags
    wr(8'h4D);
    wr(8'h25);
    err_evt(1, 0, 0);
    chk("R8 parity set", status_o[3], 1);
    chk("R8 others clear", status_o[5:4], 0);
    repeat (5) @(negedge clk);
    chk("R8 parity sticky", status_o[3], 1);
    err_evt(0, 1, 0);
    err_evt(0, 0, 1);
    chk("R8 all set", status_o[5:3], 7);
    wr(8'h35);
    chk("R9 cleared", status_o[5:3], 0);
    chk_held("R9 bit4 not stored", 8'h25);
    // clear colliding with an event: event wins
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h10; rx_ovr_err_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; rx_ovr_err_i = 1'b0;
    chk("R9 event wins", status_o[5:3], 2);
    err_evt(1, 0, 1);
    wr(8'h40);
    chk("R7 errors cleared", status_o[5:3], 0);
    wr(8'h0E);
    wr(8'h05);
    err_evt(1, 1, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 card reset errs", status_o[5:3], 0);
    chk("R1 card reset seq", wait_mode_o, 1);

    // Status layout
    for (int s = 0; s < 16; s++) begin
      tx_ready_i = s[0]; rx_ready_i = s[1]; tx_empty_i = s[2]; modem_sts_i = s[3];
      #1;
      chk("R10 status", status_o, s[0] + 2 * s[1] + 4 * s[2] + 128 * s[3]);
    end
    err_evt(0, 0, 1);
    chk("R10 framing at bit5", status_o[6:3], 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule